// File: doc/BRIEF.md
# Energize-then-hold solenoid output sequencer

This block drives the gate-enable level of one low-side switch that feeds a solenoid or relay coil. When the channel command goes high, the output is first held fully on for a programmable pull-in time, so that the armature closes reliably. After that time the output drops to PWM chopping at a programmable duty. The lower average current holds the armature and cuts coil heating.

An 8-bit control byte is loaded through a plain parallel write port. Bit 7 chooses between continuous full-on operation and the two-phase sequence. Bits 3:0 pick the pull-in time from a fixed non-linear table counted in millisecond ticks. Bits 6:4 set the hold duty in eighths. Time is measured with an external one-cycle `ms_tick` strobe. The PWM period is eight slots of `PRESCALE` clock cycles each. The control value is captured when the channel turns on, so writes made during a running sequence apply only at the next activation.

Top module: `solhold_ctrl`

## Requirements
- R1: After reset `gate_en` is 0 and the control byte is 0. Activating the channel without writing the byte therefore gives continuous full-on output.
- R2: With control bit 7 = 0, `gate_en` is 1 from the edge that first samples `chan_on` high, and stays 1 every cycle while `chan_on` stays high.
- R3: With bit 7 = 1 and bits 3:0 = c (c > 0), `gate_en` is 1 from the activation edge up to the edge that samples the N-th `ms_tick` after activation. N is taken from the list (c = 1..15): 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260, 300.
- R4: With bit 7 = 1 and bits 3:0 = 0, there is no pull-in phase, and PWM hold begins at the activation edge.
- R5: In hold, with bits 6:4 = d, `gate_en` repeats a period of 8·PRESCALE cycles that begins at hold entry. It is 1 for the first d·PRESCALE cycles of each period and 0 for the rest.
- R6: With bit 7 = 1 and duty code d = 0, `gate_en` is 0 for the whole hold phase.
- R7: `chan_on` sampled low drives `gate_en` to 0 at that edge and returns the block to idle. The next rising `chan_on` restarts the pull-in count from zero.
- R8: The mode, time code and duty are captured at activation. A control write during an active sequence leaves that sequence unchanged and takes effect at the next activation.
- R9: `ms_tick` pulses outside the pull-in phase (for example while idle) do not count toward any pull-in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Load strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte: [7] sequence enable, [6:4] hold duty, [3:0] pull-in code |
| chan_on | input | 1 | Channel on command |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| gate_en | output | 1 | Registered gate-enable level for the low-side switch |

## Verification
A wrong phase state or wrong pull-in count shows at `gate_en` as a hold pattern that starts early or late. The error is visible within one tick interval of the expected phase boundary. A wrong slot or prescale count shows up inside the first hold period as an on-time of the wrong length or position. A wrongly captured control value changes the pull-in length or duty of the current sequence at once. The bench predicts every cycle of `gate_en` from the tick schedule it drives itself, so any such error appears as a mismatch on a specific cycle.

// File: rtl/solhold_pkg.sv
package solhold_pkg;

  localparam int MS_W   = 9;   // enough for the longest pull-in (300)
  localparam int DUTY_W = 3;   // eighths
  localparam int CODE_W = 4;

  typedef struct packed {
    logic              seq_en;
    logic [DUTY_W-1:0] duty;
    logic [CODE_W-1:0] ecode;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FULL     = 2'd1,
    ST_ENERGIZE = 2'd2,
    ST_HOLD     = 2'd3
  } phase_t;

  function automatic logic [MS_W-1:0] pullin_ms(input logic [CODE_W-1:0] c);
    logic [MS_W-1:0] v;
    case (c)
      4'd0:    v = 9'd0;
      4'd1:    v = 9'd3;
      4'd2:    v = 9'd5;
      4'd3:    v = 9'd10;
      4'd4:    v = 9'd15;
      4'd5:    v = 9'd20;
      4'd6:    v = 9'd30;
      4'd7:    v = 9'd50;
      4'd8:    v = 9'd80;
      4'd9:    v = 9'd110;
      4'd10:   v = 9'd140;
      4'd11:   v = 9'd170;
      4'd12:   v = 9'd200;
      4'd13:   v = 9'd230;
      4'd14:   v = 9'd260;
      default: v = 9'd300;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/solhold_energize_timer.sv
module solhold_energize_timer
  import solhold_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              run,
  input  logic              tick,
  output logic              expire,
  output logic [MS_W-1:0]   cnt_o,
  output logic [MS_W-1:0]   dur_o
);

  logic [MS_W-1:0] cnt_q;
  logic [MS_W-1:0] dur_q;
  logic [MS_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{MS_W{1'b0}}, 1'b1};
  assign expire  = run && tick && (cnt_inc >= {1'b0, dur_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dur_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      dur_q <= pullin_ms(code);
    end else if (run && tick && !expire) begin
      cnt_q <= cnt_inc[MS_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign dur_o = dur_q;

endmodule

// File: rtl/solhold_pwm.sv
module solhold_pwm #(
  parameter int PRESCALE = 4,
  parameter int DUTY_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [DUTY_W-1:0] slot_nxt
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q, pre_nxt;
  logic [DUTY_W-1:0] slot_q;

  always_comb begin
    if (restart) begin
      pre_nxt  = '0;
      slot_nxt = '0;
    end else if (pre_q == PRE_LAST) begin
      pre_nxt  = '0;
      slot_nxt = slot_q + 1'b1;
    end else begin
      pre_nxt  = pre_q + 1'b1;
      slot_nxt = slot_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else begin
      pre_q  <= pre_nxt;
      slot_q <= slot_nxt;
    end
  end

endmodule

// File: rtl/solhold_seq.sv
module solhold_seq
  import solhold_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_on,
  input  ctrl_t             ctrl,
  input  logic              expire,
  output logic              act,
  output phase_t            state_q,
  output phase_t            state_nxt,
  output logic [DUTY_W-1:0] duty_q,
  output logic [DUTY_W-1:0] duty_nxt
);

  logic on_q;

  assign act = chan_on && !on_q;

  always_comb begin
    state_nxt = state_q;
    if (!chan_on) begin
      state_nxt = ST_IDLE;
    end else if (act) begin
      if (!ctrl.seq_en)           state_nxt = ST_FULL;
      else if (ctrl.ecode == '0)  state_nxt = ST_HOLD;
      else                        state_nxt = ST_ENERGIZE;
    end else if (state_q == ST_ENERGIZE && expire) begin
      state_nxt = ST_HOLD;
    end
  end

  assign duty_nxt = act ? ctrl.duty : duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= 1'b0;
      state_q <= ST_IDLE;
      duty_q  <= '0;
    end else begin
      on_q    <= chan_on;
      state_q <= state_nxt;
      duty_q  <= duty_nxt;
    end
  end

endmodule

// File: rtl/solhold_ctrl.sv
module solhold_ctrl
  import solhold_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       chan_on,
  input  logic       ms_tick,
  output logic       gate_en
);

  ctrl_t             ctrl_q;
  logic              act;
  logic              expire;
  phase_t            state_q, state_nxt;
  logic [DUTY_W-1:0] duty_q, duty_nxt;
  logic [DUTY_W-1:0] slot_nxt;
  logic [MS_W-1:0]   ms_cnt, dur_q;
  logic              gate_d;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  solhold_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .chan_on   (chan_on),
    .ctrl      (ctrl_q),
    .expire    (expire),
    .act       (act),
    .state_q   (state_q),
    .state_nxt (state_nxt),
    .duty_q    (duty_q),
    .duty_nxt  (duty_nxt)
  );

  solhold_energize_timer u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (act),
    .code   (ctrl_q.ecode),
    .run    (state_q == ST_ENERGIZE),
    .tick   (ms_tick),
    .expire (expire),
    .cnt_o  (ms_cnt),
    .dur_o  (dur_q)
  );

  solhold_pwm #(
    .PRESCALE (PRESCALE),
    .DUTY_W   (DUTY_W)
  ) u_pwm (
    .clk      (clk),
    .rst      (rst),
    .restart  ((state_nxt == ST_HOLD) && (state_q != ST_HOLD)),
    .slot_nxt (slot_nxt)
  );

  always_comb begin
    case (state_nxt)
      ST_FULL, ST_ENERGIZE: gate_d = 1'b1;
      ST_HOLD:              gate_d = (slot_nxt < duty_nxt);
      default:              gate_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= gate_d;
  end

endmodule

// File: rtl/solhold_ctrl_chk.sv
module solhold_ctrl_chk
  import solhold_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              chan_on,
  input logic              gate_en,
  input ctrl_t             ctrl_q,
  input phase_t            state_q,
  input logic [DUTY_W-1:0] duty_q,
  input logic [MS_W-1:0]   ms_cnt,
  input logic [MS_W-1:0]   dur_q
);

  AST_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    !chan_on |=> !gate_en);  // R7

  AST_FULL_ON_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(chan_on) && !ctrl_q.seq_en) |=> gate_en);  // R2

  AST_PULLIN_ON: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENERGIZE) |-> gate_en);  // R3

  AST_PULLIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENERGIZE) |-> (ms_cnt < dur_q));  // R3

  AST_ZERO_DUTY_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && duty_q == '0) |-> !gate_en);  // R6

  AST_SKIP_PULLIN: assert property (@(posedge clk) disable iff (rst)
    ($rose(chan_on) && ctrl_q.seq_en && ctrl_q.ecode == '0 && ctrl_q.duty != '0)
      |=> (gate_en && state_q == ST_HOLD));  // R4

endmodule

bind solhold_ctrl solhold_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .chan_on (chan_on),
  .gate_en (gate_en),
  .ctrl_q  (ctrl_q),
  .state_q (state_q),
  .duty_q  (duty_q),
  .ms_cnt  (ms_cnt),
  .dur_q   (dur_q)
);

// File: tb/solhold_ctrl_tb.sv
module solhold_ctrl_tb;

  localparam int CLK_NS = 10;
  localparam int P      = 2;   // prescale used for the bench
  localparam int TG     = 3;   // cycles between ms ticks

  logic       clk = 1'b0;
  logic       rst;
  logic       ctrl_we;
  logic [7:0] ctrl_wdata;
  logic       chan_on;
  logic       ms_tick;
  logic       gate_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int tbl [16] = '{0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260, 300};

  always #(CLK_NS/2) clk = ~clk;

  solhold_ctrl #(.PRESCALE(P)) u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .chan_on(chan_on), .ms_tick(ms_tick), .gate_en(gate_en)
  );

  task automatic chk(input bit act, input bit exp, input string req, input int cyc);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d gate_en=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  function automatic bit expect_gate(input logic [7:0] c, input int m);
    int h;
    int k;
    if (!c[7]) return 1'b1;
    h = TG * tbl[c[3:0]];
    if (m < h) return 1'b1;
    k = m - h;
    return ((k / P) % 8) < int'(c[6:4]);
  endfunction

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // Idle with ticks (R9), activate, compare every cycle, then drop (R7).
  task automatic run_case(input logic [7:0] c, input int ncyc, input string req,
                          input bit mid_wr, input logic [7:0] wv);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chan_on = 1'b0; ms_tick = (i % 2 == 0);
    end
    for (int m = 0; m < ncyc; m++) begin
      @(negedge clk);
      chan_on = 1'b1;
      ms_tick = (m > 0) && (m % TG == 0);
      ctrl_we = mid_wr && (m == 4);
      ctrl_wdata = wv;
      @(posedge clk); #1;
      chk(gate_en, expect_gate(c, m), req, m);
    end
    @(negedge clk);
    chan_on = 1'b0; ms_tick = 1'b0; ctrl_we = 1'b0;
    @(posedge clk); #1;
    chk(gate_en, 1'b0, "R7", ncyc);
  endtask

  function automatic int span(input logic [7:0] c);
    return TG * tbl[c[3:0]] + 16 * P + 3;
  endfunction

  initial begin
    rst = 1'b1; ctrl_we = 1'b0; ctrl_wdata = '0; chan_on = 1'b0; ms_tick = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(gate_en, 1'b0, "R1", 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 chk(gate_en, 1'b0, "R1", 1);

    // R1/R2: control byte still 0 after reset -> continuous full on
    run_case(8'h00, 40, "R1", 1'b0, 8'h00);
    // R2: sequence disabled, other bits ignored
    write_ctrl(8'h7F);
    run_case(8'h7F, 60, "R2", 1'b0, 8'h00);

    // R3/R5: every pull-in code, duties rotating
    for (int code = 1; code < 16; code++) begin
      logic [7:0] c;
      c = {1'b1, 3'(code % 8), 4'(code)};
      write_ctrl(c);
      run_case(c, span(c), "R3", 1'b0, 8'h00);
    end

    // R4/R5/R6: no pull-in, every duty
    for (int d = 0; d < 8; d++) begin
      logic [7:0] c;
      c = {1'b1, 3'(d), 4'd0};
      write_ctrl(c);
      run_case(c, span(c), (d == 0) ? "R6" : "R4", 1'b0, 8'h00);
    end

    // R6: zero duty after a pull-in
    write_ctrl(8'h82);
    run_case(8'h82, span(8'h82), "R6", 1'b0, 8'h00);

    // R8: mid-sequence write ignored now, used at next activation
    write_ctrl(8'hB3);
    run_case(8'hB3, span(8'hB3), "R8", 1'b1, 8'hE1);
    run_case(8'hE1, span(8'hE1), "R8", 1'b0, 8'h00);

    // R7/R9: quick re-activation restarts the count from zero
    write_ctrl(8'hC2);
    run_case(8'hC2, 7, "R7", 1'b0, 8'h00);
    run_case(8'hC2, span(8'hC2), "R9", 1'b0, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule